// File: doc/BRIEF.md
# Parallel-Prefix Binary Adder

This block adds two unsigned WIDTH-bit operands and a carry-in in one combinational pass. It returns the WIDTH-bit sum, the carry-out and the carry out of every bit position. A three-stage datapath produces every carry at once rather than letting it travel bit by bit.

The first stage forms a per-bit generate and propagate pair and folds the carry-in into bit 0. The second stage is a prefix network that merges those pairs with an associative, order-sensitive operator into group terms spanning from each bit down to bit 0. The third stage combines each group generate with the bit propagate to form the sum.

A build-time parameter selects the prefix network. The log-depth, wide network uses log2(WIDTH) levels with close to WIDTH cells per level. The sparse up-sweep/down-sweep network uses about half as many cells per level but roughly twice as many levels. Both networks produce identical outputs.

Top module: `ppa_adder`

## Requirements
- R1: {cout_o, sum_o} equals a_i + b_i + cin_i computed as a (WIDTH+1)-bit unsigned sum, for every input combination.
- R2: carry_o[i] is the carry out of bit i, which is bit i+1 of a_i[i:0] + b_i[i:0] + cin_i; the group propagate from bit i down to bit 0 is the AND of (a_i ^ b_i)[i:0].
- R3: cout_o always equals carry_o[WIDTH-1].
- R4: sum_o[i] equals a_i[i] ^ b_i[i] ^ c, where c is cin_i for bit 0 and carry_o[i-1] for every other bit.
- R5: When every bit propagates (b_i == ~a_i), cout_o equals cin_i; sum_o is all ones for cin_i = 0 and all zeros for cin_i = 1.
- R6: When every bit kills (a_i == 0 and b_i == 0), carry_o is zero and sum_o equals cin_i zero-extended.
- R7: When every bit generates (both operands all ones), every carry_o bit is 1 whatever cin_i is, and sum_o is all ones in bits WIDTH-1..1 with cin_i in bit 0.
- R8: TOPOLOGY = PPA_KOGGE_STONE (0) selects the log-depth wide network and PPA_BRENT_KUNG (1) selects the sparse up/down network; both give bit-identical sum_o, cout_o and carry_o for every input.
- R9: R1 to R4 hold for any power-of-two WIDTH of 2 or more, including an 8-bit build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| carry_o | output | WIDTH | Carry out of each bit position |

## Verification
The bench targets the longest carry chains: all ones plus one, propagate-only operands with either carry-in, and full-generate operands. A prefix network that skips or misorders a merge gives a wrong carry only at the positions its missing span covers, so every carry bit is compared rather than only the final sum.

Alternating operand patterns expose a swapped operand order in the merge operator, because such an operator lets a lower generate leak through a higher kill. A carry-in that is not folded in as the lowest position shows up as a wrong cout_o on the propagate-only vectors.

Both networks and an 8-bit build are driven with the same stimulus and compared with one another. A down-sweep level that is missing in the sparse network then appears as a mismatch against the wide one.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic {
    PPA_KOGGE_STONE = 1'b0,
    PPA_BRENT_KUNG  = 1'b1
  } ppa_topo_e;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // hi is the more significant span; operand order matters
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/ppa_setup.sv
module ppa_setup #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] g_o,
  output logic [WIDTH-1:0] p_o
);

  logic [WIDTH-1:0] gen_bit;

  assign gen_bit = a_i & b_i;
  assign p_o     = a_i ^ b_i;

  // carry-in folded in as the lowest prefix position
  assign g_o[0] = gen_bit[0] | (p_o[0] & cin_i);

  if (WIDTH > 1) begin : g_upper
    assign g_o[WIDTH-1:1] = gen_bit[WIDTH-1:1];
  end

endmodule

// File: rtl/ppa_ks_tree.sv
module ppa_ks_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] grp_g_o,
  output logic [WIDTH-1:0] grp_p_o
);

  import ppa_pkg::*;

  localparam int LEVELS = $clog2(WIDTH);

  logic [WIDTH-1:0] g_st [0:LEVELS];
  logic [WIDTH-1:0] p_st [0:LEVELS];

  assign g_st[0] = g_i;
  assign p_st[0] = p_i;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_lvl
    localparam int DIST = 1 << lvl;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= DIST) begin : g_cell
        gp_t node;
        assign node = gp_merge(gp_t'({g_st[lvl][i], p_st[lvl][i]}),
                               gp_t'({g_st[lvl][i-DIST], p_st[lvl][i-DIST]}));
        assign g_st[lvl+1][i] = node.g;
        assign p_st[lvl+1][i] = node.p;
      end else begin : g_pass
        assign g_st[lvl+1][i] = g_st[lvl][i];
        assign p_st[lvl+1][i] = p_st[lvl][i];
      end
    end
  end

  assign grp_g_o = g_st[LEVELS];
  assign grp_p_o = p_st[LEVELS];

endmodule

// File: rtl/ppa_bk_tree.sv
module ppa_bk_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] g_i,
  input  logic [WIDTH-1:0] p_i,
  output logic [WIDTH-1:0] grp_g_o,
  output logic [WIDTH-1:0] grp_p_o
);

  import ppa_pkg::*;

  localparam int LEVELS = $clog2(WIDTH);
  localparam int STAGES = 2 * LEVELS;  // stage 0 is the input

  logic [WIDTH-1:0] g_st [0:STAGES-1];
  logic [WIDTH-1:0] p_st [0:STAGES-1];

  assign g_st[0] = g_i;
  assign p_st[0] = p_i;

  // up-sweep: node i ending a block of STRIDE merges with its lower half
  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_up
    localparam int STRIDE = 1 << (lvl + 1);
    localparam int HALF   = STRIDE / 2;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (((i + 1) % STRIDE) == 0) begin : g_cell
        gp_t node;
        assign node = gp_merge(gp_t'({g_st[lvl][i], p_st[lvl][i]}),
                               gp_t'({g_st[lvl][i-HALF], p_st[lvl][i-HALF]}));
        assign g_st[lvl+1][i] = node.g;
        assign p_st[lvl+1][i] = node.p;
      end else begin : g_pass
        assign g_st[lvl+1][i] = g_st[lvl][i];
        assign p_st[lvl+1][i] = p_st[lvl][i];
      end
    end
  end

  // down-sweep: fill mid-block positions from the finished prefix below
  for (genvar d = 0; d < LEVELS - 1; d++) begin : g_dn
    localparam int LVL    = LEVELS - 2 - d;
    localparam int STRIDE = 1 << (LVL + 1);
    localparam int HALF   = STRIDE / 2;
    localparam int SRC    = LEVELS + d;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if ((((i + 1) % STRIDE) == HALF) && (i >= STRIDE)) begin : g_cell
        gp_t node;
        assign node = gp_merge(gp_t'({g_st[SRC][i], p_st[SRC][i]}),
                               gp_t'({g_st[SRC][i-HALF], p_st[SRC][i-HALF]}));
        assign g_st[SRC+1][i] = node.g;
        assign p_st[SRC+1][i] = node.p;
      end else begin : g_pass
        assign g_st[SRC+1][i] = g_st[SRC][i];
        assign p_st[SRC+1][i] = p_st[SRC][i];
      end
    end
  end

  assign grp_g_o = g_st[STAGES-1];
  assign grp_p_o = p_st[STAGES-1];

endmodule

// File: rtl/ppa_sum.sv
module ppa_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] grp_g_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [WIDTH-1:0] carry_o
);

  logic [WIDTH-1:0] carry_in;

  assign carry_in[0] = cin_i;
  if (WIDTH > 1) begin : g_shift
    assign carry_in[WIDTH-1:1] = grp_g_i[WIDTH-2:0];
  end

  assign sum_o   = prop_i ^ carry_in;
  assign carry_o = grp_g_i;
  assign cout_o  = grp_g_i[WIDTH-1];

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder #(
  parameter int                  WIDTH    = 16,
  parameter ppa_pkg::ppa_topo_e  TOPOLOGY = ppa_pkg::PPA_KOGGE_STONE
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [WIDTH-1:0] carry_o
);

  logic [WIDTH-1:0] bit_g;
  logic [WIDTH-1:0] bit_p;
  logic [WIDTH-1:0] grp_g;
  logic [WIDTH-1:0] grp_p;

  ppa_setup #(.WIDTH(WIDTH)) i_setup (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .g_o   (bit_g),
    .p_o   (bit_p)
  );

  if (TOPOLOGY == ppa_pkg::PPA_BRENT_KUNG) begin : g_bk
    ppa_bk_tree #(.WIDTH(WIDTH)) i_tree (
      .g_i     (bit_g),
      .p_i     (bit_p),
      .grp_g_o (grp_g),
      .grp_p_o (grp_p)
    );
  end else begin : g_ks
    ppa_ks_tree #(.WIDTH(WIDTH)) i_tree (
      .g_i     (bit_g),
      .p_i     (bit_p),
      .grp_g_o (grp_g),
      .grp_p_o (grp_p)
    );
  end

  ppa_sum #(.WIDTH(WIDTH)) i_sum (
    .prop_i  (bit_p),
    .grp_g_i (grp_g),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .carry_o (carry_o)
  );

endmodule

// File: rtl/ppa_adder_chk.sv
module ppa_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] carry_o,
  input logic [WIDTH-1:0] grp_p_i
);

  logic [WIDTH:0] total;
  logic [WIDTH-1:0] cin_vec;

  assign total   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign cin_vec = {carry_o[WIDTH-2:0], cin_i};

  always_comb begin
    AST_SUM_TOTAL: assert ({cout_o, sum_o} == total) else $error("sum mismatch"); // R1
    AST_COUT_TOP: assert (cout_o == carry_o[WIDTH-1]) else $error("cout mismatch"); // R3
    AST_SUM_BITS: assert (sum_o == (a_i ^ b_i ^ cin_vec)) else $error("sum bit rule"); // R4
    if ((a_i ^ b_i) == {WIDTH{1'b1}}) begin
      AST_ALL_PROP: assert (cout_o == cin_i && sum_o == {WIDTH{~cin_i}}) else $error("all-propagate"); // R5
    end
    if ((a_i | b_i) == '0) begin
      AST_ALL_KILL: assert (carry_o == '0 && sum_o == {{(WIDTH-1){1'b0}}, cin_i}) else $error("all-kill"); // R6
    end
    if ((a_i & b_i) == {WIDTH{1'b1}}) begin
      AST_ALL_GEN: assert (carry_o == {WIDTH{1'b1}} && sum_o == {{(WIDTH-1){1'b1}}, cin_i}) else $error("all-generate"); // R7
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_step
    always_comb begin
      AST_CARRY_STEP: assert (carry_o[i] == ((a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & cin_vec[i])))
        else $error("carry step"); // R2
      AST_GRP_PROP: assert (grp_p_i[i] == &(a_i[i:0] ^ b_i[i:0])) else $error("group propagate"); // R2
    end
  end

endmodule

bind ppa_adder ppa_adder_chk #(.WIDTH(WIDTH)) i_ppa_adder_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .carry_o (carry_o),
  .grp_p_i (grp_p)
);

// File: tb/test_ppa_adder.sv
`timescale 1ns/1ps
module test_ppa_adder;

  localparam int W  = 16;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a, b;
  logic          cin;
  logic [W8-1:0] a8, b8;

  logic [W-1:0]  sum_ks, sum_bk, car_ks, car_bk;
  logic          cout_ks, cout_bk;
  logic [W8-1:0] sum_8, car_8;
  logic          cout_8;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  ppa_adder #(.WIDTH(W), .TOPOLOGY(ppa_pkg::PPA_KOGGE_STONE)) i_ppa_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_ks), .cout_o(cout_ks), .carry_o(car_ks));

  ppa_adder #(.WIDTH(W), .TOPOLOGY(ppa_pkg::PPA_BRENT_KUNG)) i_ppa_adder_bk (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum_bk), .cout_o(cout_bk), .carry_o(car_bk));

  ppa_adder #(.WIDTH(W8), .TOPOLOGY(ppa_pkg::PPA_BRENT_KUNG)) i_ppa_adder_w8 (
    .a_i(a8), .b_i(b8), .cin_i(cin), .sum_o(sum_8), .cout_o(cout_8), .carry_o(car_8));

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%0d)", req, act, exp, a, b, cin);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  endtask

  function automatic longint unsigned ref_total(longint unsigned x, longint unsigned y, bit c);
    return x + y + longint'(c);
  endfunction

  function automatic longint unsigned ref_carries(longint unsigned x, longint unsigned y, bit c, int w);
    longint unsigned r = 0;
    for (int i = 0; i < w; i++) begin
      longint unsigned m = (64'd1 << (i + 1)) - 1;
      longint unsigned s = (x & m) + (y & m) + longint'(c);
      r |= ((s >> (i + 1)) & 64'd1) << i;
    end
    return r;
  endfunction

  task automatic run_vec(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    longint unsigned exp_tot, exp_car, exp_tot8, exp_car8;
    @(posedge clk);
    a = av; b = bv; cin = cv; a8 = av[W8-1:0]; b8 = bv[W8-1:0];
    @(negedge clk);
    exp_tot  = ref_total(64'(av), 64'(bv), cv);
    exp_car  = ref_carries(64'(av), 64'(bv), cv, W);
    exp_tot8 = ref_total(64'(av[W8-1:0]), 64'(bv[W8-1:0]), cv);
    exp_car8 = ref_carries(64'(av[W8-1:0]), 64'(bv[W8-1:0]), cv, W8);
    check("R1 ks total", 64'({cout_ks, sum_ks}), exp_tot);
    check("R1 bk total", 64'({cout_bk, sum_bk}), exp_tot);
    check("R2 ks carries", 64'(car_ks), exp_car);
    check("R2 bk carries", 64'(car_bk), exp_car);
    check("R3 cout is top carry", 64'(cout_ks), 64'(car_ks[W-1]));
    check("R4 sum bit rule", 64'(sum_ks), 64'(av ^ bv ^ {car_ks[W-2:0], cv}));
    check("R8 topology equivalence", 64'({cout_bk, car_bk, sum_bk}), 64'({cout_ks, car_ks, sum_ks}));
    check("R9 8-bit total", 64'({cout_8, sum_8}), exp_tot8);
    check("R9 8-bit carries", 64'(car_8), exp_car8);
    if ((av ^ bv) == '1) begin
      check("R5 all-propagate cout", 64'(cout_ks), 64'(cv));
      check("R5 all-propagate sum", 64'(sum_bk), 64'({W{~cv}}));
    end
    if ((av | bv) == '0) begin
      check("R6 all-kill carries", 64'(car_bk), 64'd0);
      check("R6 all-kill sum", 64'(sum_ks), 64'(cv));
    end
    if ((av & bv) == '1) begin
      check("R7 all-generate carries", 64'(car_ks), 64'({W{1'b1}}));
      check("R7 all-generate sum", 64'(sum_bk), 64'({{(W-1){1'b1}}, cv}));
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; a8 = '0; b8 = '0;
    repeat (2) @(posedge clk);
    run_vec(16'h0000, 16'h0000, 1'b0);   // R6
    run_vec(16'h0000, 16'h0000, 1'b1);   // R6
    run_vec(16'hFFFF, 16'h0001, 1'b0);   // all ones plus one
    run_vec(16'hFFFF, 16'h0000, 1'b1);   // R5 ripple through every bit
    run_vec(16'hFFFF, 16'h0000, 1'b0);   // R5
    run_vec(16'hFFFF, 16'hFFFF, 1'b0);   // R7
    run_vec(16'hFFFF, 16'hFFFF, 1'b1);   // R7
    run_vec(16'h5555, 16'hAAAA, 1'b0);   // R5 alternating
    run_vec(16'h5555, 16'hAAAA, 1'b1);   // R5 alternating
    run_vec(16'hAAAA, 16'hAAAA, 1'b0);
    run_vec(16'h5555, 16'h5555, 1'b1);
    run_vec(16'h8000, 16'h8000, 1'b0);
    run_vec(16'h7FFF, 16'h0001, 1'b0);
    run_vec(16'h00FF, 16'hFF00, 1'b1);   // R5 split halves
    for (int k = 0; k < 1500; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (k % 4 == 0) ? ~ra : W'($urandom);
      run_vec(ra, rb, 1'($urandom));
    end
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

endmodule